// File: doc/BRIEF.md
# TLB Entry Access Window

This block lets software load and store the entries of two translation buffers directly, through a memory-mapped window. It holds a small instruction TLB (4 entries by default) and a larger unified TLB (64 entries by default). Each entry has a tag word, a data word and a 4-bit assistance field. The most significant address byte picks one of four arrays: the address side or the data side of either buffer. Low address bits pick the entry. Two further address bits pick an access variant.

Beyond plain indexed access, a write to the unified address array can be associative. It then compares the written virtual page and address-space identifier against every entry of both buffers in parallel, in a single cycle. Only the valid and dirty bits of the entries that match are rewritten. The block does no translation for normal memory traffic, raises no exceptions and has no replacement policy.

Top module: `tlb_array_port`

## Requirements
- R1: Only requests whose address bits 31:24 equal 0xF2 (instruction address array), 0xF3 (instruction data array), 0xF6 (unified address array) or 0xF7 (unified data array) are accepted. Any other top byte gives no acknowledge, no response and no change of state.
- R2: The entry index is address bits 9:8 for the instruction TLB and address bits 13:8 for the unified TLB. The other address bits do not change which entry is chosen.
- R3: An indexed address-array write stores the write data ANDed with 0xFFFFFCFF as the tag. Data bit 8 becomes the entry's valid bit, which is data-word bit 8. For the unified TLB only, write-data bit 9 becomes the entry's dirty bit, which is data-word bit 2.
- R4: An address-array read returns the tag ORed with the valid bit at bit 8. For the unified TLB it also ORs in the dirty bit at bit 9.
- R5: A data-array write with address bit 23 clear replaces the whole 32-bit data word. A data-array read returns the whole data word, including valid (bit 8) and dirty (bit 2).
- R6: A data-array write with address bit 23 set loads only the assistance field from write-data bits 3:0. The data word is left unchanged.
- R7: A unified address-array write with address bit 7 set is associative. Every matching entry in both TLBs takes valid from write-data bit 8 and dirty from write-data bit 9. Tags, the other data-word bits and entries that do not match are left unchanged.
- R8: An entry matches when four conditions hold. Its valid bit is set. Its tag bits 31:10 equal write-data bits 31:10 on the bits its page size keeps; the size code is {data bit 7, data bit 4}, with 00 = 1 KB (all bits), 01 = 4 KB (bits 31:12), 10 = 64 KB (bits 31:16) and 11 = 1 MB (bits 31:20). Its tag bits 7:0 equal write-data bits 7:0. The last condition is waived when the shared bit, data bit 1, is set.
- R9: Reset, synchronous and active high, clears every tag, data word and assistance field, so every entry reads as invalid.
- R10: An accepted request is acknowledged combinationally in the cycle it is presented. Read data appears on the response one clock later. A write is visible to a read issued in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Access address (window, index, variant bits) |
| req_wdata | input | 32 | Store data |
| req_ack | output | 1 | Request accepted this cycle |
| rsp_valid | output | 1 | Load data valid, one cycle after an accepted load |
| rsp_data | output | 32 | Load data |

## Verification
Acknowledge is combinational, so the bench samples it 1 ns after driving the request on the falling edge. Load data passes through a single register, so the bench samples `rsp_valid` and `rsp_data` 1 ns after the next rising edge. The bench's behavioural model updates its arrays only after that sample. As a result, a load issued right after a store sees the store, as R10 requires. The associative sweep has no latency of its own. Its effect is therefore checked through ordinary loads of every entry involved, issued in the cycles that follow it.

// File: rtl/tlbp_pkg.sv
package tlbp_pkg;

    localparam int WORD_W   = 32;
    localparam int VPN_LSB  = 10;
    localparam int VPN_W    = WORD_W - VPN_LSB;
    localparam int ASID_W   = 8;
    localparam int ASSIST_W = 4;
    localparam int IDX_LSB  = 8;

    localparam logic [WORD_W-1:0] TAG_KEEP = 32'hFFFF_FCFF;

    // bit positions inside the address-array view
    localparam int AV_BIT = 8;
    localparam int AD_BIT = 9;
    // bit positions inside the stored data word
    localparam int DV_BIT  = 8;
    localparam int DD_BIT  = 2;
    localparam int DSH_BIT = 1;
    localparam int DSZ_HI  = 7;
    localparam int DSZ_LO  = 4;

    localparam logic [7:0] WIN_ITAG = 8'hF2;
    localparam logic [7:0] WIN_IDAT = 8'hF3;
    localparam logic [7:0] WIN_UTAG = 8'hF6;
    localparam logic [7:0] WIN_UDAT = 8'hF7;

    typedef enum logic [1:0] {ARR_ITAG, ARR_IDAT, ARR_UTAG, ARR_UDAT} arr_e;

    typedef struct packed {
        logic hit;
        arr_e arr;
        logic assist_only;
        logic assoc;
    } dec_t;

    function automatic dec_t decode(logic [7:0] win, logic sel_assist, logic sel_assoc);
        dec_t d;
        d.hit         = 1'b1;
        d.assist_only = sel_assist;
        d.assoc       = sel_assoc;
        case (win)
            WIN_ITAG: d.arr = ARR_ITAG;
            WIN_IDAT: d.arr = ARR_IDAT;
            WIN_UTAG: d.arr = ARR_UTAG;
            WIN_UDAT: d.arr = ARR_UDAT;
            default: begin
                d.arr = ARR_ITAG;
                d.hit = 1'b0;
            end
        endcase
        return d;
    endfunction

    function automatic logic [VPN_W-1:0] size_care(logic [1:0] sz);
        case (sz)
            2'b00:   return '1;
            2'b01:   return ~VPN_W'(32'h3);
            2'b10:   return ~VPN_W'(32'h3F);
            default: return ~VPN_W'(32'h3FF);
        endcase
    endfunction

    function automatic logic entry_match(logic [WORD_W-1:0] tag, logic [WORD_W-1:0] dat,
                                         logic [VPN_W-1:0] vpn, logic [ASID_W-1:0] asid);
        logic [VPN_W-1:0] care;
        care = size_care({dat[DSZ_HI], dat[DSZ_LO]});
        return dat[DV_BIT]
            && (((tag[WORD_W-1:VPN_LSB] ^ vpn) & care) == '0)
            && (dat[DSH_BIT] || (tag[ASID_W-1:0] == asid));
    endfunction

endpackage

// File: rtl/tlbp_bank.sv
module tlbp_bank
    import tlbp_pkg::*;
#(
    parameter int ENTRIES   = 4,
    parameter bit HAS_DIRTY = 1'b0,
    localparam int IDX_W    = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tag_we,
    input  logic              dat_we,
    input  logic              assist_we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wdata,
    input  logic              assoc_we,
    input  logic [VPN_W-1:0]  assoc_vpn,
    input  logic [ASID_W-1:0] assoc_asid,
    input  logic              assoc_v,
    input  logic              assoc_d,
    output logic [WORD_W-1:0] rd_tag_view,
    output logic [WORD_W-1:0] rd_dat_word
);

    logic [ENTRIES-1:0][WORD_W-1:0]   tag_q;
    logic [ENTRIES-1:0][WORD_W-1:0]   dat_q;
    logic [ENTRIES-1:0][ASSIST_W-1:0] assist_q;
    logic [ENTRIES-1:0]               hit_vec;
    logic [ENTRIES-1:0]               valid_vec;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g]   = entry_match(tag_q[g], dat_q[g], assoc_vpn, assoc_asid);
        assign valid_vec[g] = dat_q[g][DV_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q    <= '0;
            dat_q    <= '0;
            assist_q <= '0;
        end else begin
            if (tag_we) begin
                tag_q[idx]         <= wdata & TAG_KEEP;
                dat_q[idx][DV_BIT] <= wdata[AV_BIT];
                if (HAS_DIRTY) dat_q[idx][DD_BIT] <= wdata[AD_BIT];
            end
            if (dat_we)    dat_q[idx]    <= wdata;
            if (assist_we) assist_q[idx] <= wdata[ASSIST_W-1:0];
            if (assoc_we) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (hit_vec[i]) begin
                        dat_q[i][DV_BIT] <= assoc_v;
                        dat_q[i][DD_BIT] <= assoc_d;
                    end
                end
            end
        end
    end

    always_comb begin
        rd_tag_view = tag_q[idx];
        rd_tag_view[AV_BIT] = dat_q[idx][DV_BIT];
        if (HAS_DIRTY) rd_tag_view[AD_BIT] = dat_q[idx][DD_BIT];
        rd_dat_word = dat_q[idx];
    end

    // R3: indexed tag store keeps the masked word
    p_tag_load_r3: assert property (@(posedge clk) disable iff (rst)
        tag_we |=> tag_q[$past(idx)] == ($past(wdata) & TAG_KEEP));

    // R6: assistance load takes the low nibble and leaves data words alone
    p_assist_load_r6: assert property (@(posedge clk) disable iff (rst)
        assist_we |=> assist_q[$past(idx)] == $past(wdata[ASSIST_W-1:0]));
    p_assist_keeps_data_r6: assert property (@(posedge clk) disable iff (rst)
        (assist_we && !dat_we && !tag_we && !assoc_we) |=> $stable(dat_q));

    // R7: an associative sweep never touches any tag
    p_assoc_keeps_tags_r7: assert property (@(posedge clk) disable iff (rst)
        (assoc_we && !tag_we) |=> $stable(tag_q));

    // R9: the first cycle after reset shows no valid entry
    p_reset_clear_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (valid_vec == '0));

endmodule

// File: rtl/tlb_array_port.sv
module tlb_array_port
    import tlbp_pkg::*;
#(
    parameter int ITLB_ENTRIES = 4,
    parameter int UTLB_ENTRIES = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [31:0] req_addr,
    input  logic [31:0] req_wdata,
    output logic        req_ack,
    output logic        rsp_valid,
    output logic [31:0] rsp_data
);

    localparam int I_IDX_W = $clog2(ITLB_ENTRIES);
    localparam int U_IDX_W = $clog2(UTLB_ENTRIES);
    localparam int ASSIST_SEL_BIT = 23;
    localparam int ASSOC_SEL_BIT  = 7;

    dec_t               dec;
    logic               acc;
    logic               wr;
    logic [I_IDX_W-1:0] i_idx;
    logic [U_IDX_W-1:0] u_idx;
    logic               assoc_we;
    logic [WORD_W-1:0]  i_tag_rd, i_dat_rd, u_tag_rd, u_dat_rd;
    logic [WORD_W-1:0]  rd_mux;
    logic               rsp_valid_q;
    logic [WORD_W-1:0]  rsp_data_q;

    assign dec      = decode(req_addr[31:24], req_addr[ASSIST_SEL_BIT], req_addr[ASSOC_SEL_BIT]);
    assign acc      = req_valid && dec.hit;
    assign wr       = acc && req_write;
    assign i_idx    = req_addr[IDX_LSB +: I_IDX_W];
    assign u_idx    = req_addr[IDX_LSB +: U_IDX_W];
    assign assoc_we = wr && (dec.arr == ARR_UTAG) && dec.assoc;
    assign req_ack  = acc;

    tlbp_bank #(.ENTRIES(ITLB_ENTRIES), .HAS_DIRTY(1'b0)) u_itlb (
        .clk        (clk),
        .rst        (rst),
        .tag_we     (wr && (dec.arr == ARR_ITAG)),
        .dat_we     (wr && (dec.arr == ARR_IDAT) && !dec.assist_only),
        .assist_we  (wr && (dec.arr == ARR_IDAT) && dec.assist_only),
        .idx        (i_idx),
        .wdata      (req_wdata),
        .assoc_we   (assoc_we),
        .assoc_vpn  (req_wdata[WORD_W-1:VPN_LSB]),
        .assoc_asid (req_wdata[ASID_W-1:0]),
        .assoc_v    (req_wdata[AV_BIT]),
        .assoc_d    (req_wdata[AD_BIT]),
        .rd_tag_view(i_tag_rd),
        .rd_dat_word(i_dat_rd)
    );

    tlbp_bank #(.ENTRIES(UTLB_ENTRIES), .HAS_DIRTY(1'b1)) u_utlb (
        .clk        (clk),
        .rst        (rst),
        .tag_we     (wr && (dec.arr == ARR_UTAG) && !dec.assoc),
        .dat_we     (wr && (dec.arr == ARR_UDAT) && !dec.assist_only),
        .assist_we  (wr && (dec.arr == ARR_UDAT) && dec.assist_only),
        .idx        (u_idx),
        .wdata      (req_wdata),
        .assoc_we   (assoc_we),
        .assoc_vpn  (req_wdata[WORD_W-1:VPN_LSB]),
        .assoc_asid (req_wdata[ASID_W-1:0]),
        .assoc_v    (req_wdata[AV_BIT]),
        .assoc_d    (req_wdata[AD_BIT]),
        .rd_tag_view(u_tag_rd),
        .rd_dat_word(u_dat_rd)
    );

    always_comb begin
        case (dec.arr)
            ARR_ITAG: rd_mux = i_tag_rd;
            ARR_IDAT: rd_mux = i_dat_rd;
            ARR_UTAG: rd_mux = u_tag_rd;
            default:  rd_mux = u_dat_rd;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= acc && !req_write;
            if (acc && !req_write) rsp_data_q <= rd_mux;
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_data  = rsp_data_q;

    // R10: a response only ever follows an accepted load one cycle earlier
    p_rsp_follows_load_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && !req_write && req_ack));

    // R1: a request outside the four windows yields no response
    p_no_rsp_outside_r1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ack) |=> !rsp_valid);

    // R10: stores never produce a response
    p_no_rsp_store_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) |=> !rsp_valid);

endmodule

// File: tb/sim_tlb_array_port.sv
module sim_tlb_array_port;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr  = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ack;
    logic        rsp_valid;
    logic [31:0] rsp_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    bit [31:0] it_tag [4];
    bit [31:0] it_dat [4];
    bit [31:0] ut_tag [64];
    bit [31:0] ut_dat [64];

    always #4 clk = ~clk;

    tlb_array_port u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    task automatic check(input bit ok, input string rq, input bit [31:0] act, input bit [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", rq, act, exp);
        end
    endtask

    function automatic bit in_window(input bit [31:0] a);
        return a[31:24] == 8'hF2 || a[31:24] == 8'hF3 || a[31:24] == 8'hF6 || a[31:24] == 8'hF7;
    endfunction

    // behavioural match rule: number of low VPN bits ignored per size code
    function automatic bit mdl_hit(input bit [31:0] tag, input bit [31:0] dat, input bit [31:0] key);
        int skip;
        skip = dat[7] ? (dat[4] ? 10 : 6) : (dat[4] ? 2 : 0);
        if (!dat[8]) return 1'b0;
        if ((tag >> (10 + skip)) != (key >> (10 + skip))) return 1'b0;
        if (!dat[1] && tag[7:0] != key[7:0]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic bit [31:0] mdl_read(input bit [31:0] a);
        int i;
        int u;
        i = int'(a[9:8]);
        u = int'(a[13:8]);
        case (a[31:24])
            8'hF2:   return it_tag[i] | (32'(it_dat[i][8]) << 8);
            8'hF3:   return it_dat[i];
            8'hF6:   return ut_tag[u] | (32'(ut_dat[u][8]) << 8) | (32'(ut_dat[u][2]) << 9);
            8'hF7:   return ut_dat[u];
            default: return 32'h0;
        endcase
    endfunction

    task automatic mdl_write(input bit [31:0] a, input bit [31:0] d);
        int i;
        int u;
        i = int'(a[9:8]);
        u = int'(a[13:8]);
        case (a[31:24])
            8'hF2: begin
                it_tag[i] = d & 32'hFFFF_FCFF;
                it_dat[i][8] = d[8];
            end
            8'hF3: if (!a[23]) it_dat[i] = d;
            8'hF6: begin
                if (a[7]) begin
                    bit ih [4];
                    bit uh [64];
                    for (int k = 0; k < 4; k++)  ih[k] = mdl_hit(it_tag[k], it_dat[k], d);
                    for (int k = 0; k < 64; k++) uh[k] = mdl_hit(ut_tag[k], ut_dat[k], d);
                    for (int k = 0; k < 4; k++)  if (ih[k]) begin it_dat[k][8] = d[8]; it_dat[k][2] = d[9]; end
                    for (int k = 0; k < 64; k++) if (uh[k]) begin ut_dat[k][8] = d[8]; ut_dat[k][2] = d[9]; end
                end else begin
                    ut_tag[u] = d & 32'hFFFF_FCFF;
                    ut_dat[u][8] = d[8];
                    ut_dat[u][2] = d[9];
                end
            end
            8'hF7: if (!a[23]) ut_dat[u] = d;
            default: ;
        endcase
    endtask

    task automatic op(input bit w, input bit [31:0] a, input bit [31:0] d, input string rq);
        bit hit;
        bit [31:0] exp;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = w;
        req_addr  = a;
        req_wdata = d;
        hit = in_window(a);
        exp = mdl_read(a);
        #1;
        check(req_ack === hit, {rq, " R10 R1 ack"}, 32'(req_ack), 32'(hit));
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        check(rsp_valid === (hit && !w), {rq, " R10 rsp_valid"}, 32'(rsp_valid), 32'(hit && !w));
        if (hit && !w) check(rsp_data === exp, {rq, " data"}, rsp_data, exp);
        if (w && hit) mdl_write(a, d);
    endtask

    function automatic bit [31:0] ua(input bit [7:0] win, input int e);
        return {win, 24'h0} | (32'(e) << 8);
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(rsp_valid === 1'b0, "R9 reset rsp", 32'(rsp_valid), 32'h0);
        rst = 1'b0;

        // R9: everything invalid after reset
        for (int e = 0; e < 4; e++) op(1'b0, ua(8'hF2, e), 0, "R9");
        op(1'b0, ua(8'hF6, 0), 0, "R9");
        op(1'b0, ua(8'hF6, 63), 0, "R9");
        op(1'b0, ua(8'hF7, 40), 0, "R9");

        // R3 R4: indexed address writes and reads
        op(1'b1, ua(8'hF2, 2), 32'hABCD_E3FF, "R3");
        op(1'b0, ua(8'hF2, 2), 0, "R4");
        op(1'b1, ua(8'hF6, 63), 32'h1357_9BDF, "R3");
        op(1'b0, ua(8'hF6, 63), 0, "R4");
        op(1'b0, ua(8'hF7, 63), 0, "R3 dirty in data");
        op(1'b1, ua(8'hF6, 0), 32'hFFFF_FEFF, "R3");
        op(1'b0, ua(8'hF6, 0), 0, "R4");

        // R2: ITLB ignores address bits 13:10
        op(1'b1, 32'hF200_3100, 32'h5555_5155, "R2");
        op(1'b0, ua(8'hF2, 1), 0, "R2");
        op(1'b0, 32'hF200_2D00, 0, "R2");

        // R5 R6: data array writes
        op(1'b1, ua(8'hF7, 17), 32'hDEAD_BEEF, "R5");
        op(1'b0, ua(8'hF7, 17), 0, "R5");
        op(1'b0, ua(8'hF6, 17), 0, "R5 view");
        op(1'b1, ua(8'hF7, 17) | 32'h0080_0000, 32'h0000_0000, "R6");
        op(1'b0, ua(8'hF7, 17), 0, "R6");
        op(1'b1, ua(8'hF3, 3) | 32'h0080_0000, 32'hFFFF_FFFF, "R6");
        op(1'b0, ua(8'hF3, 3), 0, "R6");

        // R1: out-of-window traffic
        op(1'b1, 32'hF400_1100, 32'hFFFF_FFFF, "R1");
        op(1'b0, 32'hFF00_1100, 0, "R1");
        op(1'b1, 32'hE200_0200, 32'h0, "R1");
        op(1'b0, ua(8'hF6, 17), 0, "R1 no change");
        op(1'b0, ua(8'hF2, 2), 0, "R1 no change");

        // R7 R8: associative sweep setup
        op(1'b1, ua(8'hF6, 5),  32'h1234_5003, "R8 setup");
        op(1'b1, ua(8'hF7, 5),  32'h0000_0110, "R8 setup");
        op(1'b1, ua(8'hF6, 6),  32'h1234_5004, "R8 setup");
        op(1'b1, ua(8'hF7, 6),  32'h0000_0100, "R8 setup");
        op(1'b1, ua(8'hF6, 7),  32'h1234_5009, "R8 setup");
        op(1'b1, ua(8'hF7, 7),  32'h0000_0102, "R8 setup");
        op(1'b1, ua(8'hF6, 8),  32'h1234_5003, "R8 setup");
        op(1'b1, ua(8'hF7, 8),  32'h0000_0000, "R8 setup");
        op(1'b1, ua(8'hF6, 9),  32'h1234_0003, "R8 setup");
        op(1'b1, ua(8'hF7, 9),  32'h0000_0180, "R8 setup");
        op(1'b1, ua(8'hF6, 10), 32'h1234_4003, "R8 setup");
        op(1'b1, ua(8'hF7, 10), 32'h0000_0110, "R8 setup");
        op(1'b1, ua(8'hF2, 1),  32'h1234_5003, "R8 setup");
        op(1'b1, ua(8'hF3, 1),  32'h0000_0100, "R8 setup");
        op(1'b1, ua(8'hF2, 0),  32'h2234_5003, "R8 setup");
        op(1'b1, ua(8'hF3, 0),  32'h0000_0100, "R8 setup");
        op(1'b1, 32'hF600_0080, 32'h1234_5203, "R7 assoc");
        for (int e = 5; e <= 10; e++) begin
            op(1'b0, ua(8'hF7, e), 0, "R8");
            op(1'b0, ua(8'hF6, e), 0, "R7");
        end
        op(1'b0, ua(8'hF3, 1), 0, "R7 itlb");
        op(1'b0, ua(8'hF3, 0), 0, "R8 itlb");
        op(1'b1, 32'hF600_3F80, 32'h1234_5103, "R7 assoc");
        op(1'b0, ua(8'hF7, 5), 0, "R7");
        op(1'b0, ua(8'hF2, 1), 0, "R7");

        // mixed traffic against the model
        for (int n = 0; n < 1500; n++) begin
            bit [31:0] a;
            bit [31:0] d;
            int s;
            s = $urandom_range(0, 9);
            case (s)
                0, 1:    a = {8'hF2, 24'h0};
                2, 3:    a = {8'hF3, 24'h0};
                4, 5, 6: a = {8'hF6, 24'h0};
                7, 8:    a = {8'hF7, 24'h0};
                default: a = {8'hF5, 24'h0};
            endcase
            a[13:8] = 6'($urandom_range(0, 63));
            a[23]   = ($urandom_range(0, 3) == 0);
            a[7]    = ($urandom_range(0, 3) == 0);
            d = $urandom;
            d[31:12] = 20'h40000 + 20'($urandom_range(0, 3));
            d[7:0]   = 8'($urandom_range(0, 3));
            op(1'($urandom_range(0, 1)), a, d,
               (s < 4) ? "R3 R5 itlb" : (s < 9) ? "R4 R7 utlb" : "R1 outside");
        end

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'h1, 32'h0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule